// File: doc/BRIEF.md
# Split-Transaction Bus Target Responder

This block is a target on a processor bus where one 32-bit lane carries both addresses and data. A 5-bit command tells the two kinds of cycle apart. The processor marks each cycle it drives with an active-low valid. In an address cycle the command gives the direction, whether the transfer is a single access or a block, and a 2-bit size code. In a write-data cycle the lane carries one 32-bit word. The target works out from the command how many bytes and how many words the request covers. It stores write words in a 64-word internal memory. It answers a read by driving the words back over its own response lane, one word per clock, with an active-low valid and a response command. That command flags the last word and marks an error.

Only one read is open at a time. An address cycle is taken only when the processor held its active-low ready line low on the clock edge before. Malformed traffic sets a protocol-error output, which stays set until reset. Malformed traffic means an oversized request, more write data than was announced, or an address cycle while a read is still being answered.

Top module: `bus_target_responder`

## Requirements
- R1: While reset is low and after it is released, with no read taken, `rsp_vld_n_o` is 1, `rsp_cmd_o` and `rsp_ad_o` are 0, and `proto_err_o` is 0.
- R2: An address cycle is a cycle with `req_vld_n_i` = 0 and `req_cmd_i[4]` = 0. It is taken only if `ok_n_i` was 0 at the rising edge just before the one that samples it. Otherwise it starts nothing, writes nothing and raises no error.
- R3: In an address cycle, `req_cmd_i[3]` = 1 means write and 0 means read, and `req_cmd_i[2]` = 1 means block. A single access spans code+1 bytes and 1 word. A block spans 8<<code bytes and 2<<code words. The code is `req_cmd_i[1:0]`.
- R4: Any address cycle whose byte span exceeds 32 bytes sets `proto_err_o` one cycle later and starts no transfer. With the default limit this is a block with code 3.
- R5: A write-data cycle has `req_vld_n_i` = 0 and `req_cmd_i[4]` = 1. Its word k (counting from 0) of a taken write goes to memory word (`req_ad_i[7:2]` + k) mod 64, where `req_ad_i` is the write's address. Words of a write whose address has any of bits [31:8] set are taken but not stored.
- R6: A write-data word beyond the announced word count, or with no write open, sets `proto_err_o` and is not stored.
- R7: For a read whose address cycle is sampled at rising edge k and which spans n words, the words appear after edges k+1 through k+n, one per cycle with no gaps. `rsp_vld_n_o` returns to 1 after the last word.
- R8: A response word carries `rsp_cmd_o` = {1, more, 0, err, 0}. Here more = 1 on every word but the last, and err is `rsp_cmd_o[1]`.
- R9: A read whose address has any of bits [31:8] set still returns its full word count, but every word has err = 1 and data 0. An in-window read word i returns memory word (`req_ad_i[7:2]` + i) mod 64.
- R10: An address cycle that arrives while a read is still being answered sets `proto_err_o` and does not change the response sequence.
- R11: `proto_err_o` stays 1 from the cycle it is set until reset.
- R12: Every taken address cycle restarts the write word index at 0, so a new write lands at its own base even if the earlier write sent fewer words than it announced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ok_n_i | input | 1 | Active-low ready line; gates the address cycle one edge later |
| req_vld_n_i | input | 1 | Active-low valid for a processor cycle |
| req_cmd_i | input | 5 | Processor command (phase, direction, block, size code) |
| req_ad_i | input | 32 | Processor address or write data |
| rsp_vld_n_o | output | 1 | Active-low valid for a response word |
| rsp_cmd_o | output | 5 | Response command (more-words flag, error flag) |
| rsp_ad_o | output | 32 | Response data word |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
Single reads and blocks of 2, 4 and 8 words are sent to several bases. These show whether the word count and the more-flag follow the size code, and whether the response starts on the exact expected edge. A block that crosses the top of memory separates modulo indexing from a plain add. Out-of-window reads and writes separate the window check from indexing on the low address bits. A write cut short and then followed by a new write shows whether the word index is restarted by the address cycle and not carried over. The error cases each start from reset: an oversize block, excess data, data with no write open, and an address cycle during a response. Each must set the sticky flag, and the memory and response stream must stay as they were.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int CMD_W  = 5;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 7;  // largest span 64 bytes
  localparam int BEAT_W = 5;  // largest count 16 words

  typedef struct packed {
    logic              is_addr;
    logic              is_data;
    logic              is_write;
    logic [BEAT_W-1:0] words;
    logic              oversize;
  } tgt_req_t;

  function automatic logic [CMD_W-1:0] rsp_cmd(input logic more, input logic err);
    return {1'b1, more, 1'b0, err, 1'b0};
  endfunction
endpackage

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
  import tgt_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic             vld_n,
  input  logic [CMD_W-1:0] cmd,
  output tgt_req_t         dec
);
  logic [BYTE_W-1:0] bytes;

  always_comb begin
    bytes = cmd[2] ? (BYTE_W'(8) << cmd[1:0])
                   : (BYTE_W'(cmd[1:0]) + BYTE_W'(1));
    dec.is_addr  = !vld_n && !cmd[4];
    dec.is_data  = !vld_n &&  cmd[4];
    dec.is_write = cmd[3];
    dec.words    = cmd[2] ? (BEAT_W'(2) << cmd[1:0]) : BEAT_W'(1);
    dec.oversize = bytes > BYTE_W'(MAX_BYTES);
  end
endmodule

// File: rtl/tgt_word_mem.sv
module tgt_word_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] word_q [DEPTH];

  // One enabled register per word; storage carries no reset.
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic word_en;
    assign word_en = we && (waddr == IW'(w));
    always_ff @(posedge clk) begin
      if (word_en) word_q[w] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/tgt_wr_track.sv
module tgt_wr_track
  import tgt_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_go,
  input  logic              addr_wr,
  input  logic [BEAT_W-1:0] addr_words,
  input  logic [IW-1:0]     addr_base,
  input  logic              addr_inwin,
  input  logic              data_go,
  output logic              mem_we,
  output logic [IW-1:0]     mem_waddr,
  output logic              excess
);
  logic [BEAT_W-1:0] exp_q, exp_d;
  logic [BEAT_W-1:0] idx_q, idx_d;
  logic [IW-1:0]     base_q, base_d;
  logic              inwin_q, inwin_d;
  logic              upd_en;

  always_comb begin
    exp_d     = exp_q;
    idx_d     = idx_q;
    base_d    = base_q;
    inwin_d   = inwin_q;
    mem_we    = 1'b0;
    excess    = 1'b0;
    mem_waddr = base_q + IW'(idx_q);
    if (addr_go) begin
      exp_d   = addr_wr ? addr_words : '0;
      idx_d   = '0;
      base_d  = addr_base;
      inwin_d = addr_inwin;
    end else if (data_go) begin
      if (idx_q < exp_q) begin
        idx_d  = idx_q + BEAT_W'(1);
        mem_we = inwin_q;
      end else begin
        excess = 1'b1;
      end
    end
  end

  assign upd_en = addr_go || data_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      inwin_q <= 1'b0;
    end else if (upd_en) begin
      exp_q   <= exp_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      inwin_q <= inwin_d;
    end
  end
endmodule

// File: rtl/tgt_rd_seq.sv
module tgt_rd_seq
  import tgt_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] start_words,
  input  logic [IW-1:0]     start_base,
  input  logic              start_inwin,
  output logic [IW-1:0]     raddr,
  input  logic [DW-1:0]     rdata,
  output logic              busy,
  output logic              rsp_vld_n,
  output logic [CMD_W-1:0]  rsp_cmd_q,
  output logic [DW-1:0]     rsp_ad_q
);
  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] idx_q, idx_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [IW-1:0]     base_q, base_d;
  logic              inwin_q, inwin_d;
  logic              last;
  logic              vld_n_q, vld_n_d;
  logic [CMD_W-1:0]  cmd_d;
  logic [DW-1:0]     ad_d;
  logic              ctl_en, out_en;

  assign raddr = base_q + IW'(idx_q);
  assign last  = (idx_q == cnt_q - BEAT_W'(1));

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    inwin_d = inwin_q;
    if (start) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      cnt_d   = start_words;
      base_d  = start_base;
      inwin_d = start_inwin;
    end else if (busy_q) begin
      idx_d = idx_q + BEAT_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_comb begin
    vld_n_d = !busy_q;
    cmd_d   = busy_q ? rsp_cmd(!last, !inwin_q) : '0;
    ad_d    = (busy_q && inwin_q) ? rdata : '0;
  end

  assign ctl_en = start || busy_q;
  assign out_en = busy_q || !vld_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      inwin_q <= 1'b0;
    end else if (ctl_en) begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      inwin_q <= inwin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_n_q   <= 1'b1;
      rsp_cmd_q <= '0;
      rsp_ad_q  <= '0;
    end else if (out_en) begin
      vld_n_q   <= vld_n_d;
      rsp_cmd_q <= cmd_d;
      rsp_ad_q  <= ad_d;
    end
  end

  assign busy      = busy_q;
  assign rsp_vld_n = vld_n_q;
endmodule

// File: rtl/bus_target_responder.sv
module bus_target_responder
  import tgt_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int MAX_BYTES = 32,
  localparam int IW = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ok_n_i,
  input  logic              req_vld_n_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [DATA_W-1:0] req_ad_i,
  output logic              rsp_vld_n_o,
  output logic [CMD_W-1:0]  rsp_cmd_o,
  output logic [DATA_W-1:0] rsp_ad_o,
  output logic              proto_err_o
);
  tgt_req_t          dec;
  logic              ok_q;
  logic              busy;
  logic              addr_take, rd_start, wr_open;
  logic [IW-1:0]     addr_base;
  logic              addr_inwin;
  logic              mem_we, excess;
  logic [IW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic              err_q, err_d, err_set;

  tgt_cmd_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .vld_n (req_vld_n_i),
    .cmd   (req_cmd_i),
    .dec   (dec)
  );

  // Ready qualifier: sampled one edge ahead of the address cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= !ok_n_i;
  end

  assign addr_base  = req_ad_i[IW+1:2];
  assign addr_inwin = (req_ad_i[DATA_W-1:IW+2] == '0);
  assign addr_take  = dec.is_addr && ok_q && !busy;
  assign wr_open    = dec.is_write && !dec.oversize;
  assign rd_start   = addr_take && !dec.is_write && !dec.oversize;

  tgt_wr_track #(.IW(IW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_go    (addr_take),
    .addr_wr    (wr_open),
    .addr_words (dec.words),
    .addr_base  (addr_base),
    .addr_inwin (addr_inwin),
    .data_go    (dec.is_data),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .excess     (excess)
  );

  tgt_word_mem #(.DW(DATA_W), .DEPTH(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (req_ad_i),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  tgt_rd_seq #(.DW(DATA_W), .IW(IW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rd_start),
    .start_words (dec.words),
    .start_base  (addr_base),
    .start_inwin (addr_inwin),
    .raddr       (mem_raddr),
    .rdata       (mem_rdata),
    .busy        (busy),
    .rsp_vld_n   (rsp_vld_n_o),
    .rsp_cmd_q   (rsp_cmd_o),
    .rsp_ad_q    (rsp_ad_o)
  );

  // Sticky error: oversize span, address cycle during a response, surplus data.
  assign err_set = (dec.is_addr && dec.oversize) || (dec.is_addr && busy) || excess;
  assign err_d   = err_q || err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= err_d;
  end

  assign proto_err_o = err_q;
endmodule

// File: rtl/tgt_responder_chk.sv
module tgt_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld_n_i,
  input logic [4:0]  req_cmd_i,
  input logic        rsp_vld_n_o,
  input logic [4:0]  rsp_cmd_o,
  input logic [31:0] rsp_ad_o,
  input logic        proto_err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_n_o |-> (rsp_cmd_o == 5'd0 && rsp_ad_o == 32'd0));

  assert_oversize_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld_n_i && !req_cmd_i[4] && req_cmd_i[2] && req_cmd_i[1:0] == 2'b11)
      |=> proto_err_o);

  assert_more_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_vld_n_o && rsp_cmd_o[3]) |=> !rsp_vld_n_o);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_vld_n_o && !rsp_cmd_o[3]) |=> rsp_vld_n_o);

  assert_rsp_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld_n_o |-> (rsp_cmd_o[4] && !rsp_cmd_o[2] && !rsp_cmd_o[0]));

  assert_err_word_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_vld_n_o && rsp_cmd_o[1]) |-> rsp_ad_o == 32'd0);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);
endmodule

bind bus_target_responder tgt_responder_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld_n_i (req_vld_n_i),
  .req_cmd_i   (req_cmd_i),
  .rsp_vld_n_o (rsp_vld_n_o),
  .rsp_cmd_o   (rsp_cmd_o),
  .rsp_ad_o    (rsp_ad_o),
  .proto_err_o (proto_err_o)
);

// File: tb/bus_target_responder_tb_top.sv
`timescale 1ns/1ps
module bus_target_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ok_n_i;
  logic        req_vld_n_i;
  logic [4:0]  req_cmd_i;
  logic [31:0] req_ad_i;
  logic        rsp_vld_n_o;
  logic [4:0]  rsp_cmd_o;
  logic [31:0] rsp_ad_o;
  logic        proto_err_o;

  always #2.5 clk = ~clk;

  bus_target_responder dut_i (.*);

  typedef struct {
    logic [4:0]  cmd;
    logic [31:0] data;
    int          at;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model[64];
  int          edge_no = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk) edge_no <= edge_no + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops expected response words and compares data, command and cycle.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_vld_n_o !== 1'b1) begin
      if (sb_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R7: unexpected response actual cmd %0h data %0h expected none",
                 rsp_cmd_o, rsp_ad_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " cmd"},  64'(rsp_cmd_o), 64'(e.cmd));
        check({e.tag, " data"}, 64'(rsp_ad_o),  64'(e.data));
        check({e.tag, " cycle"}, 64'(edge_no),  64'(e.at));
      end
    end
  end

  task automatic bus(input logic vld_n, input logic [4:0] cmd, input logic [31:0] ad,
                     input logic okn);
    @(negedge clk);
    req_vld_n_i = vld_n;
    req_cmd_i   = cmd;
    req_ad_i    = ad;
    ok_n_i      = okn;
  endtask

  task automatic idle(input int n);
    repeat (n) bus(1'b1, 5'd0, 32'd0, 1'b1);
  endtask

  function automatic logic [4:0] acmd(input logic wr, input logic blk, input logic [1:0] code);
    return {1'b0, wr, blk, code};
  endfunction

  function automatic int nwords(input logic blk, input logic [1:0] code);
    return blk ? (2 << code) : 1;
  endfunction

  task automatic write_req(input logic [31:0] addr, input logic blk, input logic [1:0] code,
                           input int ndata, input logic [31:0] seed);
    int n;
    n = nwords(blk, code);
    bus(1'b1, 5'd0, 32'd0, 1'b0);
    bus(1'b0, acmd(1'b1, blk, code), addr, 1'b1);
    for (int i = 0; i < ndata; i++) begin
      logic [31:0] d;
      d = seed ^ (32'h0011_0101 * i);
      bus(1'b0, 5'b10000, d, 1'b1);
      if (i < n && addr[31:8] == 24'd0) model[(int'(addr[7:2]) + i) % 64] = d;
    end
    idle(1);
  endtask

  task automatic start_read(input logic [31:0] addr, input logic blk, input logic [1:0] code,
                            input string tag);
    int  n;
    int  e0;
    bit  oow;
    n   = nwords(blk, code);
    oow = (addr[31:8] != 24'd0);
    bus(1'b1, 5'd0, 32'd0, 1'b0);
    bus(1'b0, acmd(1'b0, blk, code), addr, 1'b1);
    e0 = edge_no;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cmd  = {1'b1, (i != n - 1), 1'b0, oow, 1'b0};
      e.data = oow ? 32'd0 : model[(int'(addr[7:2]) + i) % 64];
      e.at   = e0 + 2 + i;
      e.tag  = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic read_req(input logic [31:0] addr, input logic blk, input logic [1:0] code,
                          input string tag);
    start_read(addr, blk, code, tag);
    idle(nwords(blk, code) + 3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_test();
  end

  initial begin
    rst_n = 1'b0;
    ok_n_i = 1'b1;
    req_vld_n_i = 1'b1;
    req_cmd_i = '0;
    req_ad_i = '0;
    repeat (3) @(negedge clk);
    check("R1 vld_n in reset", 64'(rsp_vld_n_o), 64'd1);
    check("R1 err in reset",   64'(proto_err_o), 64'd0);
    rst_n = 1'b1;
    idle(2);
    check("R1 vld_n after reset", 64'(rsp_vld_n_o), 64'd1);
    check("R1 cmd after reset",   64'(rsp_cmd_o),   64'd0);
    check("R1 data after reset",  64'(rsp_ad_o),    64'd0);

    // Fill the whole memory with 8-word blocks.
    for (int b = 0; b < 8; b++)
      write_req(32'(b * 32), 1'b1, 2'd2, 8, 32'hA500_0000 + 32'(b * 16));

    read_req(32'h0000_0000, 1'b1, 2'd2, "R7 block8");
    read_req(32'h0000_0014, 1'b0, 2'd0, "R3 single");
    write_req(32'h0000_0014, 1'b0, 2'd3, 1, 32'h1234_5678);
    read_req(32'h0000_0014, 1'b0, 2'd3, "R5 single write");
    write_req(32'h0000_0080, 1'b1, 2'd0, 2, 32'hB0B0_0000);
    read_req(32'h0000_0080, 1'b1, 2'd0, "R3 block2");
    write_req(32'h0000_00C4, 1'b1, 2'd1, 4, 32'hC0C0_0000);
    read_req(32'h0000_00C4, 1'b1, 2'd1, "R8 block4");

    // Modulo wrap over the top of memory.
    write_req(32'h0000_00F8, 1'b1, 2'd1, 4, 32'hD0D0_0000);
    read_req(32'h0000_00F0, 1'b1, 2'd2, "R5 wrap");

    // R12: short write then a new write address.
    write_req(32'h0000_0040, 1'b1, 2'd1, 2, 32'hE1E1_0000);
    write_req(32'h0000_0060, 1'b0, 2'd3, 1, 32'hE2E2_0000);
    read_req(32'h0000_0040, 1'b1, 2'd1, "R12 short");
    read_req(32'h0000_0060, 1'b0, 2'd0, "R12 new base");

    // R9: out-of-window reads; R5: out-of-window write not stored.
    read_req(32'h1000_0040, 1'b0, 2'd0, "R9 single");
    read_req(32'h0000_0100, 1'b1, 2'd1, "R9 block");
    write_req(32'h0000_0120, 1'b0, 2'd3, 1, 32'hFFFF_0000);
    read_req(32'h0000_0020, 1'b0, 2'd0, "R5 window");

    // R2: address cycles without the ready line one edge earlier.
    bus(1'b1, 5'd0, 32'd0, 1'b1);
    bus(1'b0, acmd(1'b0, 1'b1, 2'd1), 32'h0000_0010, 1'b1);
    bus(1'b1, 5'd0, 32'd0, 1'b1);
    bus(1'b0, acmd(1'b0, 1'b0, 2'd0), 32'h0000_0010, 1'b0);
    idle(8);
    check("R2 no error when ignored", 64'(proto_err_o), 64'd0);
    check("R2 nothing pending", 64'(sb_q.size()), 64'd0);
    check("R6 clean so far", 64'(proto_err_o), 64'd0);

    // R6: excess write data.
    write_req(32'h0000_0020, 1'b0, 2'd3, 2, 32'h6666_0000);
    check("R6 excess flagged", 64'(proto_err_o), 64'd1);
    read_req(32'h0000_0020, 1'b1, 2'd0, "R6 excess not stored");
    idle(20);
    check("R11 still set", 64'(proto_err_o), 64'd1);
    do_reset();
    check("R11 cleared by reset", 64'(proto_err_o), 64'd0);

    // R6: data with no write open.
    bus(1'b0, 5'b10000, 32'h7777_7777, 1'b1);
    idle(1);
    check("R6 orphan data flagged", 64'(proto_err_o), 64'd1);
    read_req(32'h0000_0000, 1'b1, 2'd2, "R6 orphan not stored");
    do_reset();

    // R4: oversize block read.
    bus(1'b1, 5'd0, 32'd0, 1'b0);
    bus(1'b0, acmd(1'b0, 1'b1, 2'd3), 32'h0000_0000, 1'b1);
    idle(20);
    check("R4 oversize flagged", 64'(proto_err_o), 64'd1);
    check("R4 no transfer", 64'(sb_q.size()), 64'd0);
    do_reset();

    // R10: address cycle while a read is being answered.
    start_read(32'h0000_0000, 1'b1, 2'd2, "R10 stream intact");
    bus(1'b1, 5'd0, 32'd0, 1'b0);
    bus(1'b0, acmd(1'b0, 1'b0, 2'd0), 32'h0000_0040, 1'b1);
    idle(14);
    check("R10 intrusion flagged", 64'(proto_err_o), 64'd1);
    check("R10 all words seen", 64'(sb_q.size()), 64'd0);

    finish_test();
  end
endmodule